// File: doc/BRIEF.md
# Three-Lane Block FIR Filter

This block is a three-tap finite impulse response filter that handles three consecutive samples in every clock. One input word carries the samples x(3k), x(3k+1) and x(3k+2) side by side. One output word carries y(3k), y(3k+1) and y(3k+2). The sample rate is therefore three times the clock rate.

Each output lane has its own multipliers and its own adder tree. The only storage inside the filter is a small history register. It keeps the last two samples of the previous accepted block, because the first two lanes of the next block need them. Because the history advances by a whole block per clock, one register stage stands for three sample periods.

The block is meant to sit after a serial-to-parallel stage that already delivers aligned blocks in the core clock domain. The lane count and the tap count are parameters. Their defaults give the three-lane, three-tap case.

Top module: `fir3p_block`

## Requirements
- R1: Lane 0 of an output block (bits [33:0]) equals a·x(3k) + b·x(3k−1) + c·x(3k−2). Coefficient a sits in coef_i bits [15:0], b in bits [31:16] and c in bits [47:32]. Input lane 0 is in_x bits [15:0] and holds the earliest sample of the block.
- R2: Lane 1 (out_y bits [67:34]) equals a·x(3k+1) + b·x(3k) + c·x(3k−1). Input lane 1 is in_x bits [31:16].
- R3: Lane 2 (out_y bits [101:68]) equals a·x(3k+2) + b·x(3k+1) + c·x(3k). Input lane 2 is in_x bits [47:32].
- R4: The samples x(3k−1) and x(3k−2) are input lanes 2 and 1 of the most recent block accepted with in_valid high. Blocks presented with in_valid low leave this history unchanged.
- R5: out_valid equals in_valid delayed by exactly one clock. The results of a block appear in the cycle after the block is accepted.
- R6: While rst is high, and in the first cycle after it, out_valid and out_y are zero. The history is zero after reset, so the first block after reset uses zero for x(−1) and x(−2).
- R7: Samples and coefficients are 16-bit two's complement. Each output lane is 34-bit two's complement and carries the full sum with no truncation or wrap, including the case where every operand is −32768.
- R8: In a cycle that follows a clock where in_valid was low, out_y holds the value it had before that clock.
- R9: A coefficient word of all zeros gives all-zero output lanes for the block accepted with it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| coef_i | input | 48 | Tap coefficients {c, b, a}, 16-bit signed each |
| in_valid | input | 1 | Input block is present |
| in_x | input | 48 | Three input samples, lane 0 earliest |
| out_valid | output | 1 | Output block is present |
| out_y | output | 102 | Three 34-bit signed results, lane 0 earliest |

## Verification
The bench builds the filter with its default parameters: 16-bit data and coefficients, three lanes and three taps. This keeps the cross-block history at two samples, so every lane-boundary case is reached within a few blocks. Single-tap coefficient sets isolate each delay path, so a lane that reads the wrong history slot shows up directly. Mixed-sign and random coefficient sweeps, together with idle cycles mixed into the stream, are compared against a one-sample-per-step reference filter fed the same sequence in lane order. All-extreme operands push each output lane to the edge of its 34-bit range.

// File: rtl/fir3p_pkg.sv
package fir3p_pkg;
  // Full-precision width of a sum of 'taps' products of d-bit and c-bit signed values.
  function automatic int sum_width(input int d, input int c, input int taps);
    int g;
    g = 0;
    while ((1 << g) < taps) g++;
    return d + c + g;
  endfunction
endpackage

// File: rtl/fir3p_window.sv
module fir3p_window #(
  parameter int DATA_W = 16,
  parameter int LANES  = 3,
  parameter int TAPS   = 3
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                adv,
  input  logic [LANES*DATA_W-1:0]             in_x,
  output logic [(LANES+TAPS-1)*DATA_W-1:0]    win_o
);
  localparam int HIST = TAPS - 1;
  localparam int WIN  = LANES + HIST;

  logic [HIST*DATA_W-1:0] hist_q;

  // Window entry i: i < HIST is history (oldest first), then the current lanes.
  assign win_o = {in_x, hist_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
    end else if (adv) begin
      hist_q <= win_o[WIN*DATA_W-1 -: HIST*DATA_W];
    end
  end
endmodule

// File: rtl/fir3p_lane.sv
module fir3p_lane #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int LANES  = 3,
  parameter int TAPS   = 3,
  parameter int LANE   = 0,
  parameter int OUT_W  = fir3p_pkg::sum_width(DATA_W, COEF_W, TAPS)
) (
  input  logic [(LANES+TAPS-1)*DATA_W-1:0] win_i,
  input  logic [TAPS*COEF_W-1:0]           coef_i,
  output logic signed [OUT_W-1:0]          sum_o
);
  localparam int HIST   = TAPS - 1;
  localparam int PROD_W = DATA_W + COEF_W;

  logic signed [PROD_W-1:0] prod [TAPS];

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    logic signed [DATA_W-1:0] smp;
    logic signed [COEF_W-1:0] cf;
    assign smp     = win_i[(LANE+HIST-t)*DATA_W +: DATA_W];
    assign cf      = coef_i[t*COEF_W +: COEF_W];
    assign prod[t] = smp * cf;
  end

  always_comb begin
    sum_o = '0;
    for (int t = 0; t < TAPS; t++) begin
      sum_o = sum_o + OUT_W'(prod[t]);
    end
  end
endmodule

// File: rtl/fir3p_block.sv
module fir3p_block #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int LANES  = 3,
  parameter int TAPS   = 3,
  parameter int OUT_W  = fir3p_pkg::sum_width(DATA_W, COEF_W, TAPS)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [TAPS*COEF_W-1:0]    coef_i,
  input  logic                      in_valid,
  input  logic [LANES*DATA_W-1:0]   in_x,
  output logic                      out_valid,
  output logic [LANES*OUT_W-1:0]    out_y
);
  localparam int WIN = LANES + TAPS - 1;

  logic [WIN*DATA_W-1:0]     win;
  logic [LANES*OUT_W-1:0]    lane_sum;

  fir3p_window #(.DATA_W(DATA_W), .LANES(LANES), .TAPS(TAPS)) win_i (
    .clk   (clk),
    .rst   (rst),
    .adv   (in_valid),
    .in_x  (in_x),
    .win_o (win)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic signed [OUT_W-1:0] s;
    fir3p_lane #(
      .DATA_W(DATA_W), .COEF_W(COEF_W), .LANES(LANES),
      .TAPS(TAPS), .LANE(j), .OUT_W(OUT_W)
    ) lane_i (
      .win_i  (win),
      .coef_i (coef_i),
      .sum_o  (s)
    );
    assign lane_sum[j*OUT_W +: OUT_W] = s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_y     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_y <= lane_sum;
    end
  end
endmodule

// File: rtl/fir3p_block_chk.sv
module fir3p_block_chk #(
  parameter int COEF_W = 16,
  parameter int TAPS   = 3,
  parameter int LANES  = 3,
  parameter int OUT_W  = 34
) (
  input logic                    clk,
  input logic                    rst,
  input logic [TAPS*COEF_W-1:0]  coef_i,
  input logic                    in_valid,
  input logic                    out_valid,
  input logic [LANES*OUT_W-1:0]  out_y
);
  // R5: a valid block yields a valid result one clock later
  a_r5_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R5: no result without an accepted block
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R6: reset clears the output register
  a_r6_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && out_y == '0));
  // R8: idle cycles leave results untouched
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_y));
  // R9: zero coefficients give zero results
  a_r9_zero_coef: assert property (@(posedge clk) disable iff (rst)
    (in_valid && coef_i == '0) |=> (out_y == '0));
endmodule

bind fir3p_block fir3p_block_chk #(
  .COEF_W(COEF_W), .TAPS(TAPS), .LANES(LANES), .OUT_W(OUT_W)
) chk_i (
  .clk(clk), .rst(rst), .coef_i(coef_i), .in_valid(in_valid),
  .out_valid(out_valid), .out_y(out_y)
);

// File: tb/fir3p_block_tb_top.sv
module fir3p_block_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int OW = 34;
  localparam int L  = 3;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [3*DW-1:0] coef_i = '0;
  logic            in_valid = 1'b0;
  logic [L*DW-1:0] in_x = '0;
  logic            out_valid;
  logic [L*OW-1:0] out_y;

  int n_run  = 0;
  int n_fail = 0;
  longint s1 = 0, s2 = 0;
  longint ca = 0, cb = 0, cc = 0;
  longint prev_y [L];

  always #(CLK_PERIOD/2) clk = ~clk;

  fir3p_block dut_i (
    .clk(clk), .rst(rst), .coef_i(coef_i), .in_valid(in_valid),
    .in_x(in_x), .out_valid(out_valid), .out_y(out_y)
  );

  function automatic longint lane_val(input int j);
    logic signed [OW-1:0] v;
    v = out_y[j*OW +: OW];
    return longint'(v);
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_coef(input int a, input int b, input int c);
    ca = a; cb = b; cc = c;
    coef_i = {16'(c), 16'(b), 16'(a)};
  endtask

  // Called at a negedge; drives one valid block, checks at the next negedge.
  task automatic push_block(input int x0, input int x1, input int x2, input string xreq);
    longint xs [L];
    longint exp [L];
    string tags [L];
    tags[0] = "R1"; tags[1] = "R2"; tags[2] = "R3";
    xs[0] = x0; xs[1] = x1; xs[2] = x2;
    for (int j = 0; j < L; j++) begin
      exp[j] = ca*xs[j] + cb*s1 + cc*s2;
      s2 = s1; s1 = xs[j];
    end
    in_valid = 1'b1;
    in_x = {16'(x2), 16'(x1), 16'(x0)};
    @(negedge clk);
    check("R5 out_valid", longint'(out_valid), 1);
    for (int j = 0; j < L; j++) begin
      check(xreq == "" ? tags[j] : {tags[j], " ", xreq}, lane_val(j), exp[j]);
      prev_y[j] = lane_val(j);
    end
  endtask

  // Idle cycle with garbage samples: R4 history untouched, R8 output held.
  task automatic idle_cycle();
    in_valid = 1'b0;
    in_x = {16'h7fff, 16'h8001, 16'h1234};
    @(negedge clk);
    check("R5 idle out_valid", longint'(out_valid), 0);
    for (int j = 0; j < L; j++) check("R8 hold", lane_val(j), prev_y[j]);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : stim
    int ctab [6][3];
    ctab[0] = '{1, 0, 0};
    ctab[1] = '{0, 1, 0};
    ctab[2] = '{0, 0, 1};
    ctab[3] = '{3, -5, 7};
    ctab[4] = '{-32768, 32767, -1};
    ctab[5] = '{0, 0, 0};
    repeat (3) @(negedge clk);
    // R6: reset state
    check("R6 out_valid", longint'(out_valid), 0);
    for (int j = 0; j < L; j++) check("R6 out_y", lane_val(j), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R6 after reset", longint'(out_valid), 0);
    for (int j = 0; j < L; j++) prev_y[j] = 0;
    // R6: first block sees zero history
    set_coef(2, 3, 4);
    push_block(10, 20, 30, "R6 zero history");
    // Coefficient sweeps: single taps isolate each delay path (R4)
    for (int k = 0; k < 6; k++) begin
      set_coef(ctab[k][0], ctab[k][1], ctab[k][2]);
      for (int b = 0; b < 40; b++) begin
        push_block($signed(16'($urandom)), $signed(16'($urandom)),
                   $signed(16'($urandom)), k == 5 ? "R9" : "");
        if (b % 7 == 3) begin
          idle_cycle();
          idle_cycle();
          push_block(b, -b, 2*b, "R4 after idle");
        end
      end
    end
    // Random coefficient sets
    for (int k = 0; k < 30; k++) begin
      set_coef($signed(16'($urandom)), $signed(16'($urandom)), $signed(16'($urandom)));
      for (int b = 0; b < 20; b++) begin
        push_block($signed(16'($urandom)), $signed(16'($urandom)),
                   $signed(16'($urandom)), "");
        if (b % 5 == 2) idle_cycle();
      end
    end
    // R7: full precision at the extremes
    set_coef(-32768, -32768, -32768);
    for (int b = 0; b < 3; b++) push_block(-32768, -32768, -32768, "R7 max positive");
    for (int b = 0; b < 3; b++) push_block(32767, 32767, 32767, "R7 max negative");
    push_block(-32768, 32767, -32768, "R7 mixed");
    // R6: reset mid-stream clears output and history
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check("R6 reset out_valid", longint'(out_valid), 0);
    for (int j = 0; j < L; j++) check("R6 reset out_y", lane_val(j), 0);
    rst = 1'b0;
    s1 = 0; s2 = 0;
    set_coef(5, 6, 7);
    push_block(1, 2, 3, "R6 history cleared");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule